// File: doc/BRIEF.md
# Programmable serial bit-rate and timer generator

This block derives the bit-rate timing of a serial communications interface from the core clock. It also raises a periodic timer interrupt. The core clock is halved and then passes through a prescaler that divides by 1 or by 8. A 12-bit programmable divider follows, and a final stage selected by the mode comes last. In asynchronous mode that stage divides by 16, which gives one bit per 16 samples. In synchronous mode it divides by 2, which forms the shift clock. Every stage runs on the core clock and advances on single-cycle enable pulses, so the whole chain stays in one clock domain.

The block drives a one-cycle bit-rate enable to the shift logic. It also drives a serial clock output whose polarity can be inverted. The serial clock toggles on every tick of the programmable divider after a fixed /2. The timer time-out is taken either at the serial clock period or after an extra /16. While the timer enable is set, each time-out makes the interrupt pending. The pending flag stays set until the interrupt is acknowledged. A configuration write restarts the whole chain from zero.

Top module: `serial_rate_gen`

## Requirements
- R1: While reset is high and in the cycle after it, `bit_en_o` and `tmr_pend_o` are 0. `sclk_o` equals `clk_pol_i`, its idle level.
- R2: Let P be 1 when `pre8_i`=0 and 8 when `pre8_i`=1, and let D be `div_val_i`+1 (from 1 at 0x000 to 4096 at 0xFFF). The divider chain ticks once every 2·P·D core cycles, counted from restart.
- R3: When `sync_mode_i`=0, `bit_en_o` is high for exactly one cycle once every 64·P·D cycles. The first pulse is visible 64·P·D cycles after the restart edge.
- R4: When `sync_mode_i`=1, `bit_en_o` is high for one cycle once every 4·P·D cycles.
- R5: `sclk_o` is an internal phase XOR `clk_pol_i`. The phase is 0 after reset or restart and flips on every chain tick. With `clk_pol_i`=1 the output is inverted.
- R6: A timer time-out occurs every 4·P·D cycles when `tmr_slow_i`=0, and every 64·P·D cycles when `tmr_slow_i`=1. A time-out while `tmr_ie_i`=1 sets `tmr_pend_o` on the next cycle. The flag then holds until it is acknowledged.
- R7: `irq_ack_i`=1 clears `tmr_pend_o` on the next cycle. If a time-out occurs in that same cycle with `tmr_ie_i`=1, the flag stays set.
- R8: While `tmr_ie_i`=0, time-outs do not set `tmr_pend_o`.
- R9: A cycle with `cfg_wr_i`=1 clears every stage of the chain. No bit enable or time-out from that cycle takes effect. On the next cycle `bit_en_o` is 0 and `sclk_o` is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_wr_i | input | 1 | Divider/prescaler write strobe; restarts the chain |
| div_val_i | input | 12 | Divider field; ratio is value + 1 |
| pre8_i | input | 1 | Prescaler select: 0 = /1, 1 = /8 |
| tmr_slow_i | input | 1 | Timer source: 1 adds an extra /16 |
| tmr_ie_i | input | 1 | Timer interrupt enable |
| sync_mode_i | input | 1 | 0 = asynchronous (/16), 1 = synchronous (/2) |
| clk_pol_i | input | 1 | Serial clock polarity: 1 inverts |
| irq_ack_i | input | 1 | Timer interrupt acknowledge |
| bit_en_o | output | 1 | One-cycle bit-rate enable |
| sclk_o | output | 1 | Serial clock output |
| tmr_pend_o | output | 1 | Timer interrupt pending |

## Verification
The assertions assume that `div_val_i` and `pre8_i` change only together with a `cfg_wr_i` strobe. The one-cycle-pulse property further relies on the shortest period of the chain, which is four cycles. The bench respects this by changing those two fields only inside its restart task, which raises the strobe in the same cycle. The mode, polarity, enable and timer-source inputs are only selectors, so the bench changes them freely while the chain runs. Acknowledge pulses are placed both clear of time-outs and on top of them.

// File: rtl/srg_pkg.sv
package srg_pkg;
    typedef struct packed {
        logic bit_en;
        logic pend;
    } srg_out_t;
endpackage

// File: rtl/srg_prescale.sv
module srg_prescale #(
    parameter int PRE_RATIO = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic pre_sel_i,
    output logic tick_o
);
    localparam int PW = $clog2(PRE_RATIO);
    localparam logic [PW-1:0] LAST = PW'(PRE_RATIO - 1);

    typedef struct packed {
        logic          half;
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        tick_o = 1'b0;
        s_d.half = ~s_q.half;
        if (s_q.half) begin
            tick_o  = !pre_sel_i || (s_q.cnt == LAST);
            s_d.cnt = (s_q.cnt == LAST) ? '0 : s_q.cnt + 1'b1;
        end
        if (clr_i) s_d = '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end
endmodule

// File: rtl/srg_divider.sv
module srg_divider #(
    parameter int DIV_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [DIV_W-1:0] lim_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = 1'b0;
        if (en_i) begin
            if (cnt_q >= lim_i) begin
                cnt_d  = '0;
                tick_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
        if (clr_i) cnt_d = '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end
endmodule

// File: rtl/srg_post.sv
module srg_post #(
    parameter int OVS = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic en_i,
    output logic phase_o,
    output logic half_tick_o,
    output logic ovs_tick_o
);
    localparam int OW = $clog2(OVS);
    localparam logic [OW-1:0] LAST = OW'(OVS - 1);

    typedef struct packed {
        logic          ph;
        logic [OW-1:0] cnt;
    } post_st_t;

    post_st_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        half_tick_o = 1'b0;
        ovs_tick_o  = 1'b0;
        if (en_i) begin
            s_d.ph      = ~s_q.ph;
            half_tick_o = s_q.ph;
        end
        if (half_tick_o) begin
            ovs_tick_o = (s_q.cnt == LAST);
            s_d.cnt    = (s_q.cnt == LAST) ? '0 : s_q.cnt + 1'b1;
        end
        if (clr_i) s_d = '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign phase_o = s_q.ph;
endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
    import srg_pkg::*;
#(
    parameter int DIV_W     = 12,
    parameter int PRE_RATIO = 8,
    parameter int OVS       = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cfg_wr_i,
    input  logic [DIV_W-1:0] div_val_i,
    input  logic             pre8_i,
    input  logic             tmr_slow_i,
    input  logic             tmr_ie_i,
    input  logic             sync_mode_i,
    input  logic             clk_pol_i,
    input  logic             irq_ack_i,
    output logic             bit_en_o,
    output logic             sclk_o,
    output logic             tmr_pend_o
);
    logic pre_tick, div_tick, half_tick, ovs_tick, phase;
    logic timeout;
    srg_out_t o_d, o_q;

    srg_prescale #(.PRE_RATIO(PRE_RATIO)) i_pre (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clr_i     (cfg_wr_i),
        .pre_sel_i (pre8_i),
        .tick_o    (pre_tick)
    );

    srg_divider #(.DIV_W(DIV_W)) i_div (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (cfg_wr_i),
        .en_i   (pre_tick),
        .lim_i  (div_val_i),
        .tick_o (div_tick)
    );

    srg_post #(.OVS(OVS)) i_post (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .clr_i       (cfg_wr_i),
        .en_i        (div_tick),
        .phase_o     (phase),
        .half_tick_o (half_tick),
        .ovs_tick_o  (ovs_tick)
    );

    always_comb begin
        o_d     = o_q;
        timeout = !cfg_wr_i && (tmr_slow_i ? ovs_tick : half_tick);
        o_d.bit_en = !cfg_wr_i && (sync_mode_i ? half_tick : ovs_tick);
        if (timeout && tmr_ie_i) o_d.pend = 1'b1;
        else if (irq_ack_i)      o_d.pend = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) o_q <= '0;
        else       o_q <= o_d;
    end

    assign bit_en_o   = o_q.bit_en;
    assign tmr_pend_o = o_q.pend;
    assign sclk_o     = phase ^ clk_pol_i;
endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
    parameter int DIV_W = 12
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             cfg_wr_i,
    input logic [DIV_W-1:0] div_val_i,
    input logic             pre8_i,
    input logic             tmr_slow_i,
    input logic             tmr_ie_i,
    input logic             sync_mode_i,
    input logic             clk_pol_i,
    input logic             irq_ack_i,
    input logic             bit_en_o,
    input logic             sclk_o,
    input logic             tmr_pend_o
);
    a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_en_o |=> !bit_en_o);

    a_r6_pend_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (tmr_pend_o && !irq_ack_i) |=> tmr_pend_o);

    a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_ack_i && !tmr_ie_i) |=> !tmr_pend_o);

    a_r8_masked_no_set: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tmr_ie_i && !tmr_pend_o) |=> !tmr_pend_o);

    a_r9_restart_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_wr_i |=> (!bit_en_o && (sclk_o == clk_pol_i)));
endmodule

bind serial_rate_gen srg_checker #(.DIV_W(DIV_W)) i_chk (.*);

// File: tb/test_serial_rate_gen.sv
module test_serial_rate_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic [11:0] cd = '0;
    logic        pre8 = 1'b0, slow = 1'b0, ie = 1'b0, sync = 1'b0, pol = 1'b1, ack = 1'b0;
    logic        bit_en, sclk, pend;

    int total = 0, bad = 0;
    int cycles = 0;
    string cur = "R1";
    bit live = 1'b0;

    longint n = 0, l2 = 2;
    bit e_en = 1'b0, e_pend = 1'b0;

    always #4 clk = ~clk;

    serial_rate_gen i_serial_rate_gen (
        .clk_i(clk), .rst_i(rst), .cfg_wr_i(wr), .div_val_i(cd), .pre8_i(pre8),
        .tmr_slow_i(slow), .tmr_ie_i(ie), .sync_mode_i(sync), .clk_pol_i(pol),
        .irq_ack_i(ack), .bit_en_o(bit_en), .sclk_o(sclk), .tmr_pend_o(pend)
    );

    task automatic chk(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference: position in the chain counted in core cycles
    always @(posedge clk) begin
        bit t;
        if (rst) begin
            n = 0; e_en = 0; e_pend = 0; t = 0;
            l2 = 2 * (pre8 ? 8 : 1) * (longint'(cd) + 1);
        end else begin
            l2 = 2 * (pre8 ? 8 : 1) * (longint'(cd) + 1);
            if (wr) begin
                n = 0; e_en = 0; t = 0;
            end else begin
                e_en = sync ? (((n + 1) % (2 * l2)) == 0) : (((n + 1) % (32 * l2)) == 0);
                t    = slow ? (((n + 1) % (32 * l2)) == 0) : (((n + 1) % (2 * l2)) == 0);
                n = n + 1;
            end
            if (t && ie) e_pend = 1;
            else if (ack) e_pend = 0;
        end
    end

    always @(negedge clk) begin
        if (live) begin
            chk(cur, "bit_en", bit_en, e_en);
            chk(cur, "pend", pend, e_pend);
            chk(cur, "sclk", sclk, ((n / l2) % 2) ^ pol);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run(int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic restart(logic [11:0] v, logic p);
        @(posedge clk); #1;
        cd = v; pre8 = p; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    initial begin
        int cnt;
        // R1 reset state
        run(3);
        chk("R1", "bit_en in reset", bit_en, 0);
        chk("R1", "pend in reset", pend, 0);
        chk("R1", "sclk idle pol=1", sclk, 1);
        rst = 1'b0; pol = 1'b0;
        #1;
        chk("R1", "sclk idle pol=0", sclk, 0);
        live = 1'b1;

        // R3 asynchronous, smallest ratio: 64 cycles per bit
        cur = "R3";
        restart(12'h000, 1'b0);
        cnt = 0;
        for (int k = 0; k < 650; k++) begin
            @(negedge clk);
            if (bit_en) cnt++;
        end
        chk("R3", "pulses in 650 cycles", cnt, 10);

        // R2 prescaler by 8 with divider 3: 1536 cycles per async bit
        cur = "R2";
        restart(12'h002, 1'b1);
        cnt = 0;
        for (int k = 0; k < 3200; k++) begin
            @(negedge clk);
            if (bit_en) cnt++;
        end
        chk("R2", "pulses with /8 prescale", cnt, 2);

        // R4 synchronous: 24 cycles per bit
        cur = "R4";
        sync = 1'b1;
        restart(12'h005, 1'b0);
        cnt = 0;
        for (int k = 0; k < 250; k++) begin
            @(negedge clk);
            if (bit_en) cnt++;
        end
        chk("R4", "sync pulses in 250 cycles", cnt, 10);

        // R2 boundary: largest divider field
        cur = "R2";
        restart(12'hFFF, 1'b0);
        cnt = 0;
        for (int k = 0; k < 16500; k++) begin
            @(negedge clk);
            if (bit_en) cnt++;
        end
        chk("R2", "pulses at divider 4096", cnt, 1);

        // R5 polarity inversion while running
        cur = "R5";
        restart(12'h001, 1'b0);
        run(37);
        pol = 1'b1;
        run(41);
        pol = 1'b0;
        run(20);

        // R6 timer time-outs set pending
        cur = "R6";
        ie = 1'b1; slow = 1'b0;
        restart(12'h001, 1'b0);
        run(20);
        chk("R6", "pend after fast time-out", pend, 1);
        run(30);
        slow = 1'b1;
        ack = 1'b1; run(1); ack = 1'b0;
        run(300);
        chk("R6", "pend after slow time-out", pend, 1);

        // R7 acknowledge, including coincident with a time-out
        cur = "R7";
        slow = 1'b0;
        for (int k = 0; k < 40; k++) begin
            ack = 1'b1; run(1); ack = 1'b0; run(k % 5);
        end
        ack = 1'b1; run(2); ack = 1'b0;

        // R8 masked time-outs
        cur = "R8";
        ie = 1'b0;
        ack = 1'b1; run(1); ack = 1'b0;
        for (int k = 0; k < 10; k++) begin
            run(20);
            chk("R8", "pend masked", pend, 0);
        end

        // R9 restart mid-run
        cur = "R9";
        sync = 1'b1; ie = 1'b1;
        for (int k = 0; k < 8; k++) begin
            run(3 + k);
            restart(12'h000, 1'b0);
            chk("R9", "bit_en after restart", bit_en, 0);
            chk("R9", "sclk idle after restart", sclk, pol);
        end
        run(60);

        live = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule